// File: doc/BRIEF.md
# Dual-Limit Event Timer

This block is a 16-bit up-counting timer with two maximum-count (limit) registers, a primary and a secondary. In the single-limit mode it repeats over the primary limit. On every limit match its output pin drops low for one clock. In the alternating mode it hands control back and forth between the two limits. The output level then shows which limit is in control, so the two values set the high and low times of a variable duty-cycle waveform.

The counter advances on timer events. An event is either an internal tick that comes once every fourth system clock, or a rising edge of an external input that has passed through a synchronizer. On the cycle the count would reach the active limit, the counter returns to zero, so the stored count never equals that limit. A match sets a sticky flag and, when interrupts are enabled, sends a one-cycle request pulse.

Software sees four registers on a simple synchronous bus. Reads are registered and return one cycle after the address is presented. The count can be read or overwritten at any time, whether or not the timer is running.

Top module: `evtimer_top`

## Requirements
- R1: While enabled with the internal source, the count advances by exactly one every fourth system clock, so a primary limit L produces matches exactly 4*L clocks apart.
- R2: When the next count would equal the active limit, the count register is loaded with 0 in that same cycle. The stored count therefore never holds the limit, and reads 0 right after a match.
- R3: In single-limit mode (control bit 1 = 0) the output is high, except for exactly one clock low beginning with each match.
- R4: In alternating mode (control bit 1 = 1) the output is high while the primary limit (address 2) is in control and low while the secondary limit (address 3) is in control. Each match swaps control, giving a high time of 4*primary and a low time of 4*secondary clocks.
- R5: A limit value of 0 acts as a 65536-count range: from a count of 65530 the next match comes six events later.
- R6: The count (address 1) and both limits can be written and read back at any time. A bus write to the count takes priority over a timer event in the same cycle. Reads return the addressed register one cycle after the address is presented.
- R7: Control bit 0 enables counting and control bit 2 selects continuous operation. With bit 2 = 0 the block clears bit 0 itself after the first match in single-limit mode, or after the secondary match in alternating mode, and no further matches occur.
- R8: Every match sets sticky flag bit 5 of the control register. A control write with bit 5 = 0 clears the flag. When control bit 4 = 1, a match also drives the request output high for exactly one clock. With bit 4 = 0 the request stays low.
- R9: With control bit 3 = 1 the counter advances only on rising edges of the external input and ignores internal ticks. The request for a match answers within 6 clocks of the input edge that caused it.
- R10: After reset the count and the control register read 0, the output is high and the request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 count, 2 primary limit, 3 secondary limit |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for the addressed register |
| ext_in | input | 1 | External event input (asynchronous) |
| tmr_out | output | 1 | Registered waveform output |
| irq | output | 1 | One-cycle match request pulse |

## Verification
The hardest case to reach from the ports is the 65536-count range of a zero limit. Counting there from zero would take far longer than the run allows. The bench therefore stops the timer, writes the count to just below the wrap point and restarts it, then times the match against six internal ticks. The other hard case is the end of an alternating one-shot. The bench starts it from a known phase and counts exactly two requests before checking that the enable bit has dropped and the output has returned high.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] A_PRI   = 2'd2;
  localparam logic [ADDR_W-1:0] A_SEC   = 2'd3;

  localparam int B_RUN   = 0;
  localparam int B_ALT   = 1;
  localparam int B_CONT  = 2;
  localparam int B_EXT   = 3;
  localparam int B_IEN   = 4;
  localparam int B_FLAG  = 5;
  localparam int B_PHASE = 6;

  typedef struct packed {
    logic ien;
    logic ext;
    logic cont;
    logic alt;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/evtimer_tick.sv
module evtimer_tick #(
  parameter int PRE_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_sel,
  input  logic ext_in,
  output logic evt
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0]     pre_q;
  logic [SYNC_STAGES:0] sync_q;
  logic                 int_tick;
  logic                 ext_rise;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else if (pre_q == PRE_LAST) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else sync_q <= {sync_q[SYNC_STAGES-1:0], ext_in};
  end

  assign int_tick = (pre_q == PRE_LAST);
  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign evt      = ext_sel ? ext_rise : int_tick;

  // R1: internal ticks are never back to back
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    int_tick |=> !int_tick);
  // R9: one synchronized edge gives one event
  assert_edge_single_R9: assert property (@(posedge clk) disable iff (rst)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/evtimer_core.sv
module evtimer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             run,
  input  logic             alt,
  input  logic             cont,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] lim_pri,
  input  logic [CNT_W-1:0] lim_sec,
  output logic [CNT_W-1:0] count,
  output logic             phase,
  output logic             match,
  output logic             stop
);
  localparam logic [CNT_W:0] FULL_RANGE = {1'b1, {CNT_W{1'b0}}};

  logic             adv;
  logic [CNT_W-1:0] lim_act;
  logic [CNT_W:0]   lim_eff;
  logic [CNT_W:0]   nxt;

  assign adv     = run & evt;
  assign lim_act = phase ? lim_sec : lim_pri;
  assign lim_eff = (lim_act == '0) ? FULL_RANGE : {1'b0, lim_act};
  assign nxt     = {1'b0, count} + 1'b1;
  assign match   = adv & (nxt == lim_eff);
  assign stop    = match & ~cont & (~alt | phase);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (cnt_we) count <= cnt_wdata;
    else if (match) count <= '0;
    else if (adv) count <= nxt[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else if (!alt) phase <= 1'b0;
    else if (match) phase <= ~phase;
  end

  // R2: a match leaves zero behind, never the limit
  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (match && !cnt_we) |=> (count == '0));
  // R1: one event advances the count by exactly one
  assert_step_one_R1: assert property (@(posedge clk) disable iff (rst)
    (adv && !match && !cnt_we) |=> (count == $past(count) + 1'b1));
  // R4: each alternating match swaps the controlling limit
  assert_phase_swap_R4: assert property (@(posedge clk) disable iff (rst)
    (alt && match) |=> (phase != $past(phase)));
endmodule

// File: rtl/evtimer_regs.sv
module evtimer_regs
  import evtimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              match,
  input  logic              stop,
  input  logic              phase,
  input  logic [CNT_W-1:0]  count,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  lim_pri,
  output logic [CNT_W-1:0]  lim_sec,
  output logic              cnt_we,
  output logic [CNT_W-1:0]  rdata
);
  logic ctrl_wr;
  logic flag;

  assign ctrl_wr = we && (addr == A_CTRL);
  assign cnt_we  = we && (addr == A_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl.run  <= wdata[B_RUN];
      ctrl.alt  <= wdata[B_ALT];
      ctrl.cont <= wdata[B_CONT];
      ctrl.ext  <= wdata[B_EXT];
      ctrl.ien  <= wdata[B_IEN];
    end else if (stop) begin
      ctrl.run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else if (match) flag <= 1'b1;
    else if (ctrl_wr && !wdata[B_FLAG]) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_pri <= '0;
      lim_sec <= '0;
    end else if (we) begin
      if (addr == A_PRI) lim_pri <= wdata;
      if (addr == A_SEC) lim_sec <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_CTRL:  rdata <= CNT_W'({phase, flag, ctrl});
        A_COUNT: rdata <= count;
        A_PRI:   rdata <= lim_pri;
        default: rdata <= lim_sec;
      endcase
    end
  end

  // R8: a match always leaves the sticky flag set
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    match |=> flag);
  // R7: a one-shot end drops the enable unless software rewrites it
  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (stop && !ctrl_wr) |=> !ctrl.run);
endmodule

// File: rtl/evtimer_wave.sv
module evtimer_wave (
  input  logic clk,
  input  logic rst,
  input  logic alt,
  input  logic phase,
  input  logic match,
  input  logic ien,
  output logic out_q,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      out_q <= alt ? ~(phase ^ match) : ~match;
      irq_q <= match & ien;
    end
  end

  // R8: the request is a single-cycle pulse
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
  import evtimer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              ext_in,
  output logic              tmr_out,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] lim_pri, lim_sec, count;
  logic             cnt_we, evt, phase, match, stop;

  evtimer_tick #(.PRE_DIV(PRE_DIV), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .ext_sel(ctrl.ext), .ext_in(ext_in), .evt(evt));

  evtimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .match(match), .stop(stop), .phase(phase), .count(count), .ctrl(ctrl),
    .lim_pri(lim_pri), .lim_sec(lim_sec), .cnt_we(cnt_we), .rdata(reg_rdata));

  evtimer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .evt(evt), .run(ctrl.run), .alt(ctrl.alt),
    .cont(ctrl.cont), .cnt_we(cnt_we), .cnt_wdata(reg_wdata),
    .lim_pri(lim_pri), .lim_sec(lim_sec), .count(count), .phase(phase),
    .match(match), .stop(stop));

  evtimer_wave u_wave (
    .clk(clk), .rst(rst), .alt(ctrl.alt), .phase(phase), .match(match),
    .ien(ctrl.ien), .out_q(tmr_out), .irq_q(irq));

  // R4: in alternating mode the pin shows the controlling limit
  assert_level_tracks_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl.alt |=> (tmr_out == !phase));
endmodule

// File: tb/tb_evtimer_top.sv
module tb_evtimer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ext_in = 1'b0;
  logic        tmr_out;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evtimer_top dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_in(ext_in),
    .tmr_out(tmr_out), .irq(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_irq(input int maxc, output int cyc);
    cyc = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (irq) begin cyc = i; break; end
    end
  endtask

  task automatic halt_clear();
    logic [15:0] v;
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
    rd(2'd0, v);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk(tmr_out == 1'b1, "R10 out high", tmr_out, 1);
    chk(irq == 1'b0, "R10 irq low", irq, 0);
    rd(2'd0, v); chk(v == 16'h0, "R10 ctrl zero", v, 0);
    rd(2'd1, v); chk(v == 16'h0, "R10 count zero", v, 0);
  endtask

  task automatic t_regrw();
    logic [15:0] v;
    wr(2'd1, 16'd1234); rd(2'd1, v); chk(v == 16'd1234, "R6 count rw", v, 1234);
    wr(2'd2, 16'd100);  rd(2'd2, v); chk(v == 16'd100, "R6 primary rw", v, 100);
    wr(2'd3, 16'd200);  rd(2'd3, v); chk(v == 16'd200, "R6 secondary rw", v, 200);
    wr(2'd1, 16'd0);
  endtask

  task automatic t_periodic();
    int c1, c2, maxv;
    logic [15:0] v;
    bit eqlim;
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0015);
    wait_irq(100, c1);
    chk(c1 > 0, "R8 irq seen", c1, 1);
    chk(tmr_out == 1'b0, "R3 low at match", tmr_out, 0);
    @(negedge clk);
    chk(tmr_out == 1'b1, "R3 low one clock", tmr_out, 1);
    wait_irq(100, c2);
    chk(c2 + 1 == 20, "R1 period 4*L", c2 + 1, 20);
    reg_addr = 2'd1;
    @(negedge clk);
    @(negedge clk);
    chk(reg_rdata == 16'd0, "R2 zero after match", reg_rdata, 0);
    maxv = 0; eqlim = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (reg_rdata > maxv) maxv = reg_rdata;
      if (reg_rdata == 16'd5) eqlim = 1;
    end
    chk(!eqlim, "R2 never holds limit", maxv, 4);
    chk(maxv == 4, "R2 max stored count", maxv, 4);
    rd(2'd0, v);
    chk(v[5] == 1'b1, "R8 flag set", v[5], 1);
    halt_clear();
    rd(2'd0, v);
    chk(v[5] == 1'b0, "R8 flag cleared", v[5], 0);
  endtask

  task automatic t_noirq();
    int seen, lows;
    logic [15:0] v;
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0005);
    seen = 0; lows = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (irq) seen++;
      if (!tmr_out) lows++;
    end
    chk(seen == 0, "R8 irq masked", seen, 0);
    chk(lows == 5, "R3 low pulses per match", lows, 5);
    rd(2'd0, v);
    chk(v[5] == 1'b1, "R8 flag without irq", v[5], 1);
    halt_clear();
  endtask

  task automatic t_alt();
    int lo, hi;
    wr(2'd2, 16'd3);
    wr(2'd3, 16'd5);
    wr(2'd0, 16'h0007);
    while (tmr_out) @(negedge clk);
    lo = 0; while (!tmr_out) begin lo++; @(negedge clk); end
    hi = 0; while (tmr_out) begin hi++; @(negedge clk); end
    chk(lo == 20, "R4 low time 4*sec", lo, 20);
    chk(hi == 12, "R4 high time 4*pri", hi, 12);
    halt_clear();
  endtask

  task automatic t_oneshot();
    int c, seen;
    logic [15:0] v;
    wr(2'd2, 16'd4);
    wr(2'd0, 16'h0011);
    wait_irq(100, c);
    chk(c > 0, "R7 one-shot match", c, 1);
    rd(2'd0, v);
    chk(v[0] == 1'b0, "R7 enable cleared", v[0], 0);
    seen = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (irq) seen++; end
    chk(seen == 0, "R7 no further match", seen, 0);
    halt_clear();
    wr(2'd2, 16'd2);
    wr(2'd3, 16'd3);
    wr(2'd0, 16'h0013);
    seen = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (irq) seen++; end
    chk(seen == 2, "R7 alt one-shot matches", seen, 2);
    chk(tmr_out == 1'b1, "R7 alt one-shot ends high", tmr_out, 1);
    rd(2'd0, v);
    chk(v[0] == 1'b0, "R7 alt enable cleared", v[0], 0);
    halt_clear();
  endtask

  task automatic t_fullrange();
    int c;
    logic [15:0] v;
    wr(2'd2, 16'd0);
    wr(2'd1, 16'd65530);
    wr(2'd0, 16'h0015);
    wait_irq(60, c);
    chk(c >= 21 && c <= 28, "R5 zero limit wraps at 65536", c, 24);
    rd(2'd1, v);
    chk(v < 16'd4, "R5 count wrapped small", v, 0);
    halt_clear();
  endtask

  task automatic t_livewrite();
    logic [15:0] v;
    wr(2'd2, 16'd1000);
    wr(2'd0, 16'h0005);
    repeat (10) @(negedge clk);
    wr(2'd1, 16'd500);
    rd(2'd1, v);
    chk(v >= 16'd500 && v <= 16'd502, "R6 write while running", v, 500);
    halt_clear();
  endtask

  task automatic t_external();
    int seen, c;
    logic [15:0] v;
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h001D);
    repeat (40) @(negedge clk);
    rd(2'd1, v);
    chk(v == 16'd0, "R9 internal ticks ignored", v, 0);
    seen = 0;
    for (int p = 0; p < 2; p++) begin
      @(negedge clk); ext_in = 1'b1;
      for (int i = 0; i < 8; i++) begin @(negedge clk); if (irq) seen++; end
      ext_in = 1'b0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); if (irq) seen++; end
    end
    chk(seen == 0, "R9 no match before third edge", seen, 0);
    rd(2'd1, v);
    chk(v == 16'd2, "R9 two edges counted", v, 2);
    @(negedge clk); ext_in = 1'b1;
    wait_irq(6, c);
    chk(c > 0 && c <= 6, "R9 response within 6 clocks", c, 3);
    @(negedge clk); ext_in = 1'b0;
    halt_clear();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regrw();
    t_periodic();
    t_noirq();
    t_alt();
    t_oneshot();
    t_fullrange();
    t_livewrite();
    t_external();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule